// File: doc/BRIEF.md
# Triggered Long-Interval Timer Counter

This block is a synchronous timer that counts falling edges of a slow timebase input and produces two square-wave outputs: one at half the timebase rate, and one at 1/256 of it. The system clock times the block. The timebase, the start input and the clear input are ordinary digital levels. The two asynchronous ones (start and timebase) pass through two-flop synchronizers, and edges on them are detected in the system clock domain.

After system reset the block sits idle with both outputs high, and it ignores the timebase. A rising edge on the start input begins a timing run. Both outputs drop low, and the 8-stage counter starts from zero. The slow output goes high again after 128 falling timebase edges. In repeating mode that output keeps alternating every 128 edges. In single-shot mode the block stops at that point and returns to idle until the next start edge. A high clear level forces idle, but only while the synchronized start level is low.

Top module: `ltimer_top`

## Requirements
- R1: After the synchronous reset `rst`, the block is idle and both `div2_out` and `div256_out` are 1.
- R2: While `clear_in` is 1 and the synchronized `start_in` level is 0, the block goes idle and both outputs are 1.
- R3: While the synchronized `start_in` level is 1, `clear_in` has no effect. A clear held across a start pulse takes effect once `start_in` falls.
- R4: A rising edge of `start_in` while idle starts a run. Both outputs become 0 and the count restarts at 0.
- R5: A rising edge of `start_in` during a run has no effect on the count or the outputs.
- R6: Only falling edges of `tb_in` advance the count. Rising edges do not, and neither does any edge while idle.
- R7: During a run, `div2_out` equals bit 0 of the count of falling edges since the start. It is 1 after an odd number of edges.
- R8: During a run, `div256_out` equals bit 7 of that count, so it rises after the 128th falling edge.
- R9: With `repeat_mode` = 1, the count wraps modulo 256. `div256_out` alternates every 128 falling edges.
- R10: With `repeat_mode` = 0, the 128th falling edge ends the run. The block goes idle with both outputs at 1, and it ignores later timebase edges until the next start edge.
- R11: A change on `start_in` or `tb_in` reaches the outputs at the third rising clock edge that samples it, or earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| start_in | input | 1 | Start request, asynchronous; its rising edge begins a run |
| clear_in | input | 1 | Clear-to-idle level, synchronous to clk |
| tb_in | input | 1 | Timebase, asynchronous; counted on falling edges |
| repeat_mode | input | 1 | 1 = repeating, 0 = single-shot |
| div2_out | output | 1 | Half-rate output, registered |
| div256_out | output | 1 | 1/256-rate output, registered |

## Verification
The assertions assume that each level of `start_in` and `tb_in` lasts long enough for both synchronizer stages to capture it. They also assume that `clear_in` and `repeat_mode` are stable around clock edges. The stimulus holds every timebase and start level for three clock cycles and changes inputs only on the falling clock edge. It also changes `repeat_mode` only between timebase edges, so every edge gives exactly one detection pulse.

// File: rtl/ltimer_pkg.sv
package ltimer_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tmr_state_t;
endpackage

// File: rtl/ltimer_sync.sv
module ltimer_sync #(
  parameter int STAGES  = 2,
  parameter bit DET_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic pulse
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      prev_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], din};
      prev_q <= shreg[STAGES-1];
    end
  end

  assign lvl = shreg[STAGES-1];

  generate
    if (DET_RISE) begin : g_rise
      assign pulse = lvl & ~prev_q;
    end else begin : g_fall
      assign pulse = ~lvl & prev_q;
    end
  endgenerate

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R6
endmodule

// File: rtl/ltimer_chain.sv
module ltimer_chain #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load0,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nx
);
  always_comb begin
    if (load0)     cnt_nx = '0;
    else if (step) cnt_nx = cnt + 1'b1;
    else           cnt_nx = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load0 && cnt == {W{1'b1}}) |=> cnt == '0); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load0) |=> $stable(cnt)); // R6
endmodule

// File: rtl/ltimer_top.sv
module ltimer_top #(
  parameter int CNT_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_in,
  input  logic clear_in,
  input  logic tb_in,
  input  logic repeat_mode,
  output logic div2_out,
  output logic div256_out
);
  import ltimer_pkg::*;

  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  tmr_state_t        state, state_n;
  logic              st_lvl, st_rise, tb_lvl, tb_fall;
  logic              clr_eff, start_go, adv, stop;
  logic [CNT_W-1:0]  cnt, cnt_nx;

  ltimer_sync #(.STAGES(SYNC_STGS), .DET_RISE(1'b1)) u_st_sync (
    .clk(clk), .rst(rst), .din(start_in), .lvl(st_lvl), .pulse(st_rise));

  ltimer_sync #(.STAGES(SYNC_STGS), .DET_RISE(1'b0)) u_tb_sync (
    .clk(clk), .rst(rst), .din(tb_in), .lvl(tb_lvl), .pulse(tb_fall));

  assign clr_eff  = clear_in & ~st_lvl;
  assign start_go = st_rise & (state == ST_IDLE);
  assign adv      = (state == ST_RUN) & tb_fall & ~clr_eff;
  assign stop     = adv & ~repeat_mode & (cnt_nx == HALF);

  ltimer_chain #(.W(CNT_W)) u_chain (
    .clk(clk), .rst(rst), .load0(start_go), .step(adv),
    .cnt(cnt), .cnt_nx(cnt_nx));

  always_comb begin
    state_n = state;
    if (clr_eff)       state_n = ST_IDLE;
    else if (start_go) state_n = ST_RUN;
    else if (stop)     state_n = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      div2_out   <= 1'b1;
      div256_out <= 1'b1;
    end else begin
      state <= state_n;
      if (state_n == ST_RUN) begin
        div2_out   <= cnt_nx[0];
        div256_out <= cnt_nx[CNT_W-1];
      end else begin
        div2_out   <= 1'b1;
        div256_out <= 1'b1;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (div2_out && div256_out)); // R1
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (clear_in && !st_lvl) |=> (state == ST_IDLE && div2_out && div256_out)); // R2
  AST_CLEAR_MASKED: assert property (@(posedge clk) disable iff (rst)
    (st_lvl && state == ST_RUN) |=> state == ST_RUN); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    start_go |=> (!div2_out && !div256_out)); // R4
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    tb_fall |-> !tb_lvl); // R6
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !repeat_mode && tb_fall && !clr_eff && cnt == HALF - 1'b1)
      |=> (state == ST_IDLE && div2_out && div256_out)); // R10
endmodule

// File: tb/ltimer_top_bench.sv
module ltimer_top_bench;
  logic clk = 1'b0;
  logic rst, start_in, clear_in, tb_in, repeat_mode;
  logic div2_out, div256_out;

  int n_chk = 0;
  int n_bad = 0;
  bit m_run = 1'b0;
  int m_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ltimer_top u_ltimer_top (
    .clk(clk), .rst(rst), .start_in(start_in), .clear_in(clear_in),
    .tb_in(tb_in), .repeat_mode(repeat_mode),
    .div2_out(div2_out), .div256_out(div256_out));

  function automatic bit exp_d2();
    return m_run ? m_cnt[0] : 1'b1;
  endfunction
  function automatic bit exp_d256();
    return m_run ? m_cnt[7] : 1'b1;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req);
    n_chk++;
    if (div2_out !== exp_d2() || div256_out !== exp_d256()) begin
      n_bad++;
      $display("FAIL %s: d2=%b d256=%b expected d2=%b d256=%b",
               req, div2_out, div256_out, exp_d2(), exp_d256());
    end
  endtask

  task automatic tb_fall_op();
    tb_in = 1'b1; wait_cyc(3);
    tb_in = 1'b0; wait_cyc(3);
    if (m_run) begin
      m_cnt = (m_cnt + 1) % 256;
      if (!repeat_mode && m_cnt == 128) m_run = 1'b0;
    end
  endtask

  task automatic start_op();
    start_in = 1'b1; wait_cyc(3);
    if (!m_run) begin m_run = 1'b1; m_cnt = 0; end
    start_in = 1'b0; wait_cyc(3);
  endtask

  task automatic clear_op();
    clear_in = 1'b1; wait_cyc(3);
    m_run = 1'b0;
    clear_in = 1'b0; wait_cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; start_in = 1'b0; clear_in = 1'b0; tb_in = 1'b0; repeat_mode = 1'b1;
    wait_cyc(3);
    rst = 1'b0; wait_cyc(1);
    check("R1 reset state");

    tb_fall_op(); check("R6 idle ignores timebase");

    start_op(); check("R4 start drives outputs low");
    tb_in = 1'b1; wait_cyc(3); check("R6 rising timebase edge ignored");
    tb_in = 1'b0; wait_cyc(3); m_cnt = 1; check("R11 fall visible within 3 clocks");
    tb_fall_op(); check("R7 even count low");
    start_op(); check("R5 retrigger during run ignored");
    for (int i = 0; i < 125; i++) tb_fall_op();
    check("R8 before 128th fall");
    tb_fall_op(); check("R8 after 128th fall");
    for (int i = 0; i < 128; i++) tb_fall_op();
    check("R9 wrap to low after 256");
    for (int i = 0; i < 128; i++) tb_fall_op();
    check("R9 second period high");

    start_in = 1'b1; wait_cyc(3);
    clear_in = 1'b1; wait_cyc(3);
    check("R3 clear masked while start high");
    start_in = 1'b0; wait_cyc(3); m_run = 1'b0;
    check("R3 clear acts after start falls");
    clear_in = 1'b0; wait_cyc(1);
    check("R2 idle after clear");

    repeat_mode = 1'b0;
    start_op();
    for (int i = 0; i < 127; i++) tb_fall_op();
    check("R10 one-shot before end");
    tb_fall_op(); check("R10 one-shot ended idle");
    tb_fall_op(); tb_fall_op(); check("R10 later edges ignored");
    start_op(); check("R10 restart after one-shot");
    tb_fall_op(); check("R7 odd count high");

    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 85)      tb_fall_op();
      else if (r < 92) start_op();
      else if (r < 95) clear_op();
      else begin repeat_mode = $urandom_range(0, 1); wait_cyc(1); end
      check("R9 R10 random sequence");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule